// File: doc/BRIEF.md
# ADC Single-Conversion Sequencer

This block is the control and status logic that sits between a processor bus and a multi-channel successive-approximation converter. Software writes a control register to pick an input channel, enable the interrupt and set a start bit. The sequencer then sends one conversion request to the converter and waits for the answer. When the answer arrives, it files the sample in the result register that belongs to that channel, raises a completion flag and drops the start bit on its own.

The converter itself is outside the block and is reached through a small handshake. A one-cycle request pulse carries a channel number. A one-cycle answer pulse, which may come after any latency, carries a 10-bit sample.

Software acknowledges a completion with a read-then-write sequence on the flag. Clearing the start bit while a conversion is running abandons that conversion.

Top module: `adcSeqTop`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `convStart` is 0.
- R2: Register map on the bus. Offset 0 is the control register: bit 0 start, bit 1 mode, bits 4:2 channel code, bit 5 interrupt enable, bit 7 completion flag, all other bits read 0. Offsets 4 to 7 hold the results of channels 0 to 3 in bits 9:0. Every other offset reads 0. `busRdata` is 0 unless `busSel` and `busRd` are both high. Writes to the result offsets are ignored.
- R3: A write to offset 0 with start=1 and mode=0 while idle produces `convStart` high for exactly the following cycle. `convCh` then equals the channel code carried by that same write.
- R4: An answer pulse during a conversion does all of the following at the same clock edge: it stores `convData` into the result register of the running channel, sets the flag, clears the start bit and returns the sequencer to idle.
- R5: Writing 0 to the flag clears it only if offset 0 was read with the flag at 1 since the flag was last set. Writing 1 to the flag never changes it.
- R6: `irq` is high exactly when both the flag and the interrupt enable are 1.
- R7: Writing start=0 during a conversion abandons it. No result is stored and the flag is unchanged.
- R8: Changes to the channel field while a conversion runs are stored and read back, but the running conversion still files its result under the channel it started with.
- R9: A result register keeps its value until a later conversion on the same channel finishes.
- R10: A conversion started with a channel code of 4 to 7 runs and sets the flag, but writes no result register.
- R11: A start written together with mode=1 launches no conversion, and the start bit reads back 0.
- R12: An answer pulse while idle changes neither the results nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 3 | Register offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| convStart | output | 1 | One-cycle conversion request to the converter |
| convCh | output | 3 | Channel of the current request |
| convDone | input | 1 | One-cycle answer from the converter |
| convData | input | 10 | Sample that comes with `convDone` |

## Verification
The bench builds the block with its defaults: four channels, a 3-bit channel code and 10-bit samples. With a 3-bit code and only four result registers, the codes 4 to 7 can be driven, so the unmapped-channel path is exercised alongside the mapped one. A behavioural model in the bench predicts the read data, `irq` and the request pulse on every cycle. The scenarios cover the following corners:
- varying converter latency;
- an abandoned conversion followed by a stale answer;
- a channel rewrite in mid-conversion;
- the read-before-clear rule for the flag.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  localparam int CH_SEL_W = 3;

  // control register bit positions
  localparam int BIT_GO   = 0;
  localparam int BIT_MODE = 1;
  localparam int BIT_CH   = 2;
  localparam int BIT_IE   = 5;
  localparam int BIT_FLAG = 7;

  // decoded bus events, datapath to control
  typedef struct packed {
    logic                goReq;
    logic                scanReq;
    logic                goDrop;
    logic [CH_SEL_W-1:0] chan;
  } busEvt_t;

  // strobes, control to datapath
  typedef struct packed {
    logic                commit;
    logic                goClear;
    logic                busy;
    logic [CH_SEL_W-1:0] chan;
  } seqStrobe_t;
endpackage

// File: rtl/adcSeqFsm.sv
module adcSeqFsm
  import adcSeqPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  busEvt_t             evt,
  input  logic                convDone,
  output seqStrobe_t          strb,
  output logic                convStart,
  output logic [CH_SEL_W-1:0] convCh
);
  typedef enum logic {ST_IDLE, ST_CONV} seqState_t;

  seqState_t           state;
  logic [CH_SEL_W-1:0] latCh;
  logic                launch;
  logic                abortHit;
  logic                commit;

  always_comb begin
    launch   = (state == ST_IDLE) && evt.goReq;
    abortHit = (state == ST_CONV) && evt.goDrop;
    commit   = (state == ST_CONV) && convDone && !abortHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      latCh     <= '0;
      convStart <= 1'b0;
    end else begin
      convStart <= launch;
      if (launch) begin
        state <= ST_CONV;
        latCh <= evt.chan;
      end else if (abortHit || commit) begin
        state <= ST_IDLE;
      end
    end
  end

  always_comb begin
    strb.commit  = commit;
    strb.goClear = (state == ST_IDLE) && evt.scanReq;
    strb.busy    = (state == ST_CONV);
    strb.chan    = latCh;
  end

  assign convCh = latCh;
endmodule

// File: rtl/adcSeqRegs.sv
module adcSeqRegs
  import adcSeqPkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_W    = 10,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int RES_BASE = 4
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busSel,
  input  logic                          busWr,
  input  logic                          busRd,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [BUS_W-1:0]              busWdata,
  output logic [BUS_W-1:0]              busRdata,
  output logic                          irq,
  input  seqStrobe_t                    strb,
  input  logic [RES_W-1:0]              convData,
  output busEvt_t                       evt,
  output logic                          goQ,
  output logic                          flagQ,
  output logic                          armQ,
  output logic [NUM_CH-1:0][RES_W-1:0]  resBank
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = '0;

  logic                wrCtl;
  logic                rdCtl;
  logic                modeQ;
  logic                ieQ;
  logic [CH_SEL_W-1:0] chanQ;
  logic                flagClr;
  logic                unusedBits;

  assign unusedBits = ^{busWdata[BUS_W-1:BIT_FLAG+1], busWdata[BIT_FLAG-1:BIT_IE+1], strb.busy};

  always_comb begin
    wrCtl       = busSel && busWr && (busAddr == CTL_ADDR);
    rdCtl       = busSel && busRd && (busAddr == CTL_ADDR);
    evt.goReq   = wrCtl && busWdata[BIT_GO] && !busWdata[BIT_MODE];
    evt.scanReq = wrCtl && busWdata[BIT_GO] && busWdata[BIT_MODE];
    evt.goDrop  = wrCtl && !busWdata[BIT_GO];
    evt.chan    = busWdata[BIT_CH +: CH_SEL_W];
    flagClr     = wrCtl && !busWdata[BIT_FLAG] && armQ && !strb.commit;
  end

  // start, mode, channel and interrupt enable fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goQ   <= 1'b0;
      modeQ <= 1'b0;
      ieQ   <= 1'b0;
      chanQ <= '0;
    end else begin
      if (strb.commit || strb.goClear) goQ <= 1'b0;
      else if (wrCtl)                  goQ <= busWdata[BIT_GO];
      if (wrCtl) begin
        modeQ <= busWdata[BIT_MODE];
        ieQ   <= busWdata[BIT_IE];
        chanQ <= busWdata[BIT_CH +: CH_SEL_W];
      end
    end
  end

  // completion flag and its read-arm bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      armQ  <= 1'b0;
    end else begin
      if (strb.commit)  flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
      if (strb.commit || flagClr)  armQ <= 1'b0;
      else if (rdCtl && flagQ)     armQ <= 1'b1;
    end
  end

  // one result register per mapped channel
  for (genvar k = 0; k < NUM_CH; k++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resBank[k] <= '0;
      else if (strb.commit && (strb.chan == CH_SEL_W'(k))) resBank[k] <= convData;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busSel && busRd) begin
      if (busAddr == CTL_ADDR) begin
        busRdata[BIT_GO]                = goQ;
        busRdata[BIT_MODE]              = modeQ;
        busRdata[BIT_CH +: CH_SEL_W]    = chanQ;
        busRdata[BIT_IE]                = ieQ;
        busRdata[BIT_FLAG]              = flagQ;
      end
      for (int k = 0; k < NUM_CH; k++) begin
        if (busAddr == ADDR_W'(RES_BASE + k)) busRdata = BUS_W'(resBank[k]);
      end
    end
  end

  assign irq = flagQ && ieQ;
endmodule

// File: rtl/adcSeqTop.sv
module adcSeqTop
  import adcSeqPkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RES_W    = 10,
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int RES_BASE = 4
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  output logic                irq,
  output logic                convStart,
  output logic [CH_SEL_W-1:0] convCh,
  input  logic                convDone,
  input  logic [RES_W-1:0]    convData
);
  busEvt_t                      evt;
  seqStrobe_t                   strb;
  logic                         goQ;
  logic                         flagQ;
  logic                         armQ;
  logic [NUM_CH-1:0][RES_W-1:0] resBank;

  adcSeqRegs #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .BUS_W(BUS_W),
    .ADDR_W(ADDR_W), .RES_BASE(RES_BASE)
  ) u_regs (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .strb(strb), .convData(convData), .evt(evt),
    .goQ(goQ), .flagQ(flagQ), .armQ(armQ), .resBank(resBank)
  );

  adcSeqFsm u_fsm (
    .clk(clk), .rstN(rstN), .evt(evt), .convDone(convDone),
    .strb(strb), .convStart(convStart), .convCh(convCh)
  );
endmodule

// File: rtl/adcSeqChecker.sv
module adcSeqChecker #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10
)(
  input logic                         clk,
  input logic                         rstN,
  input logic                         convStart,
  input logic                         commit,
  input logic                         goQ,
  input logic                         flagQ,
  input logic                         armQ,
  input logic [NUM_CH-1:0][RES_W-1:0] resBank
);
  AST_START_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R3
  AST_FLAG_RISE_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(commit)); // R4
  AST_GO_LOW_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !goQ); // R4
  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ) |-> $past(armQ)); // R5
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(resBank)); // R9
endmodule

bind adcSeqTop adcSeqChecker #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .commit(strb.commit),
  .goQ(goQ), .flagQ(flagQ), .armQ(armQ), .resBank(resBank)
);

// File: tb/test_adcSeqTop.sv
module test_adcSeqTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq, convStart;
  logic [2:0]  convCh;
  logic        convDone = 1'b0;
  logic [9:0]  convData = '0;

  always #2 clk = ~clk;

  adcSeqTop i_adcSeqTop (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .convStart(convStart), .convCh(convCh), .convDone(convDone), .convData(convData)
  );

  int checks = 0, fails = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit       mGo, mMode, mIe, mFlag, mArm, mBusy, mStart;
  bit [2:0] mChan, mLat;
  bit [9:0] mRes [4];

  always @(posedge clk) begin
    if (!rstN) begin
      mGo = 0; mMode = 0; mIe = 0; mFlag = 0; mArm = 0; mBusy = 0; mStart = 0;
      mChan = 0; mLat = 0;
      foreach (mRes[i]) mRes[i] = 0;
    end else begin
      bit wr, rd, startNow, dropNow, doneNow, clr;
      wr = busSel && busWr && busAddr == 0;
      rd = busSel && busRd && busAddr == 0;
      startNow = !mBusy && wr && busWdata[0] && !busWdata[1];
      dropNow  = mBusy && wr && !busWdata[0];
      doneNow  = mBusy && convDone && !dropNow;
      clr      = wr && !busWdata[7] && mArm && !doneNow;
      if (doneNow && mLat < 4) mRes[mLat] = convData;
      if (doneNow) begin mFlag = 1; mArm = 0; end
      else if (clr) begin mFlag = 0; mArm = 0; end
      else if (rd && mFlag) mArm = 1;
      if (wr) begin
        mGo = mBusy ? busWdata[0] : (busWdata[0] && !busWdata[1]);
        mMode = busWdata[1]; mChan = busWdata[4:2]; mIe = busWdata[5];
      end
      if (doneNow) mGo = 0;
      mStart = startNow;
      if (startNow) begin mBusy = 1; mLat = busWdata[4:2]; end
      else if (dropNow || doneNow) mBusy = 0;
    end
  end

  function automatic logic [15:0] modelRead();
    logic [15:0] v = '0;
    if (busSel && busRd) begin
      if (busAddr == 0) v = {8'h00, mFlag, 1'b0, mIe, mChan, mMode, mGo};
      else if (busAddr >= 4) v = {6'h00, mRes[busAddr-4]};
    end
    return v;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      check(convStart == mStart, "R3 convStart", convStart, mStart);
      if (mStart) check(convCh == mLat, "R3 convCh", convCh, mLat);
      check(irq == (mFlag && mIe), "R6 irq", irq, mFlag && mIe);
      check(busRdata == modelRead(), "R2 busRdata", busRdata, modelRead());
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic rdExpect(input logic [2:0] a, input logic [15:0] exp, input string req);
    busSel = 1; busRd = 1; busAddr = a;
    @(negedge clk);
    check(busRdata == exp, req, busRdata, exp);
    @(posedge clk); #1;
    busSel = 0; busRd = 0;
  endtask

  task automatic expectStart(input logic [2:0] ch, input string req);
    check(convStart == 1'b1, req, convStart, 1);
    check(convCh == ch, req, convCh, ch);
  endtask

  task automatic finishConv(input int lat, input logic [9:0] d);
    repeat (lat) begin @(posedge clk); #1; end
    convDone = 1; convData = d;
    @(posedge clk); #1;
    convDone = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;

    // R1 reset state
    check(irq == 0, "R1 irq", irq, 0);
    check(convStart == 0, "R1 convStart", convStart, 0);
    rdExpect(0, 16'h0000, "R1 ctrl");
    for (int a = 4; a < 8; a++) rdExpect(3'(a), 16'h0000, "R1 result");

    // R3/R4: channel 1, interrupt enabled
    busWrite(0, 16'h0025);
    expectStart(1, "R3 start ch1");
    finishConv(3, 10'h2A5);
    check(irq == 1, "R6 irq set", irq, 1);
    rdExpect(5, 16'h02A5, "R4 result ch1");

    // R5: clear without prior read does nothing
    busWrite(0, 16'h0020);
    rdExpect(0, 16'h00A0, "R5 no clear without read");
    busWrite(0, 16'h00A0);
    rdExpect(0, 16'h00A0, "R5 write one keeps flag");
    busWrite(0, 16'h0020);
    rdExpect(0, 16'h0020, "R5 cleared after read");
    check(irq == 0, "R6 irq low", irq, 0);

    // R7/R12: abort then stale answer
    busWrite(0, 16'h0009);
    expectStart(2, "R3 start ch2");
    @(posedge clk); #1;
    busWrite(0, 16'h0008);
    finishConv(2, 10'h111);
    rdExpect(6, 16'h0000, "R7 abort no store");
    rdExpect(0, 16'h0008, "R7 abort flag clear");

    // R8: channel rewrite mid-conversion
    busWrite(0, 16'h000D);
    expectStart(3, "R3 start ch3");
    busWrite(0, 16'h0001);
    finishConv(4, 10'h3FF);
    rdExpect(7, 16'h03FF, "R8 latched channel");
    rdExpect(4, 16'h0000, "R8 new channel untouched");
    rdExpect(0, 16'h0080, "R8 fields readback");
    check(irq == 0, "R6 irq masked", irq, 0);
    busWrite(0, 16'h0000);

    // R9: overwrite same channel only
    busWrite(0, 16'h0005);
    expectStart(1, "R3 start ch1 again");
    finishConv(1, 10'h055);
    rdExpect(5, 16'h0055, "R9 overwrite");
    rdExpect(7, 16'h03FF, "R9 other kept");
    rdExpect(0, 16'h0084, "R9 ctrl");
    busWrite(0, 16'h0000);

    // R10: unmapped channel code
    busWrite(0, 16'h0015);
    expectStart(5, "R10 start ch5");
    finishConv(2, 10'h0AA);
    rdExpect(0, 16'h0094, "R10 flag set");
    rdExpect(4, 16'h0000, "R10 r4");
    rdExpect(5, 16'h0055, "R10 r5");
    rdExpect(6, 16'h0000, "R10 r6");
    rdExpect(7, 16'h03FF, "R10 r7");
    busWrite(0, 16'h0000);

    // R11: start with scan mode
    busWrite(0, 16'h0007);
    check(convStart == 0, "R11 no start", convStart, 0);
    rdExpect(0, 16'h0006, "R11 go reads 0");

    // R2: result offsets not writable, hole reads 0
    busWrite(5, 16'h0123);
    rdExpect(5, 16'h0055, "R2 result read only");
    rdExpect(1, 16'h0000, "R2 hole");

    // R12: answer while idle
    finishConv(0, 10'h3C3);
    rdExpect(0, 16'h0006, "R12 flag unchanged");
    rdExpect(4, 16'h0000, "R12 result unchanged");

    // R3: start together with new channel and enable
    busWrite(0, 16'h002D);
    expectStart(3, "R3 new fields used");
    finishConv(5, 10'h200);
    check(irq == 1, "R6 irq again", irq, 1);
    rdExpect(7, 16'h0200, "R4 result ch3");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule